// File: doc/BRIEF.md
# Polled Peripheral Port

This block connects a simple processor bus to one byte-wide peripheral. It answers only at its own pair of bus addresses. One address takes command codes on writes and returns a status byte on reads. The other address takes the outgoing data byte on writes and returns the last byte received from the device on reads. One byte is held in each direction, so the processor and the slower device never have to be in step.

Progress is visible only through the status byte. The block has no interrupt line. After the processor issues a read or write command it polls until BUSY clears. After a read has finished it also waits for READY. Bytes from the device carry an even-parity bit, and a mismatch is kept as a sticky error flag until the processor reads status. On the device side there is a ready/valid byte handshake in each direction. A byte moves on any cycle where both valid and ready are high.

Bus accesses are single-cycle strobes. Read data appears on `bus_rdata` one clock after the access and stays there until the next matched read or test command.

Top module: `polled_io_port`

## Requirements
- R1: An access with `bus_sel` high whose `bus_addr[ADDR_W-1:1]` differs from `DEV_BASE` changes no state and leaves `bus_rdata` and `dev_enable` unchanged.
- R2: After reset the status byte is 0x00, `bus_rdata` is 0x00, and `dev_enable`, `dev_rx_ready` and `dev_tx_valid` are low. The status byte has READY at bit 0, BUSY at bit 1, parity error at bit 2, enabled at bit 3, and zeros above.
- R3: A command write (address offset 0) with code 0 in `bus_wdata[1:0]` copies `bus_wdata[2]` into the enabled flag. That flag drives `dev_enable` and status bit 3 from the next cycle.
- R4: Command code 1 (test) puts the current status byte on `bus_rdata` one cycle later and does not clear the parity error flag.
- R5: Command code 2 (read) is accepted when the port is enabled and not busy. It sets BUSY, clears READY and holds `dev_rx_ready` high until a receive handshake. That handshake clears BUSY and sets READY.
- R6: A read or write command issued while BUSY is set, or while the port is disabled, is ignored: status and the device-side outputs are unchanged.
- R7: A bus read at offset 1 returns the buffered received byte one cycle later and clears READY. When READY is already clear, it returns the buffer and leaves status unchanged.
- R8: A received byte whose parity bit differs from the XOR of its eight data bits sets status bit 2. The flag stays set across test commands and is cleared by a bus read at offset 0, which returns the status as it stood before the clear.
- R9: A bus write at offset 1 loads the transmit buffer unless BUSY is set. Command code 3 (write) raises `dev_tx_valid` with that byte and its even-parity bit and keeps them steady until `dev_tx_ready`, with BUSY set the whole time.
- R10: `dev_rx_valid` has no effect unless a read command is pending: the buffer and status are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Bus address; bit 0 selects command/status or data |
| bus_wdata | input | DATA_W | Write data or command byte |
| bus_rdata | output | DATA_W | Registered read result |
| dev_enable | output | 1 | Device enabled by control command |
| dev_rx_valid | input | 1 | Device offers a byte |
| dev_rx_data | input | DATA_W | Byte from device |
| dev_rx_par | input | 1 | Even-parity bit of the byte from device |
| dev_rx_ready | output | 1 | Port will take a byte from device |
| dev_tx_valid | output | 1 | Port offers a byte to device |
| dev_tx_data | output | DATA_W | Byte to device |
| dev_tx_par | output | 1 | Even-parity bit of the byte to device |
| dev_tx_ready | input | 1 | Device takes the offered byte |

## Verification
The receive path is exercised with random bytes, with good and deliberately corrupted parity, and with random device latency. These runs separate a correct parity check from an inverted or missing one, and show that READY and BUSY change only at the handshake, not at the command. The transmit path is exercised with random bytes and stall lengths. It shows that the data and parity stay steady under back-pressure and that a buffer write during a transfer does not reach the device. Directed cases cover foreign addresses, commands while disabled or busy, device traffic with no read pending, and the difference between a test command and a status read in their effect on the error flag.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        CMD_CTRL  = 2'd0,
        CMD_TEST  = 2'd1,
        CMD_READ  = 2'd2,
        CMD_WRITE = 2'd3
    } pio_cmd_e;

    localparam int ST_READY    = 0;
    localparam int ST_BUSY     = 1;
    localparam int ST_PERR     = 2;
    localparam int ST_EN       = 3;
    localparam int CTRL_EN_BIT = 2;
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode #(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-2:0] DEV_BASE = '0
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              ctl_rd,
    output logic              ctl_wr,
    output logic              dat_rd,
    output logic              dat_wr
);
    logic hit;

    always_comb begin
        hit    = bus_sel && (bus_addr[ADDR_W-1:1] == DEV_BASE);
        ctl_rd = hit && !bus_we && !bus_addr[0];
        ctl_wr = hit &&  bus_we && !bus_addr[0];
        dat_rd = hit && !bus_we &&  bus_addr[0];
        dat_wr = hit &&  bus_we &&  bus_addr[0];
    end
endmodule

// File: rtl/pio_even_parity.sv
module pio_even_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    output logic         par
);
    always_comb par = ^data;
endmodule

// File: rtl/polled_io_port.sv
module polled_io_port
    import pio_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 8,
    parameter logic [ADDR_W-2:0] DEV_BASE = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dev_enable,
    input  logic              dev_rx_valid,
    input  logic [DATA_W-1:0] dev_rx_data,
    input  logic              dev_rx_par,
    output logic              dev_rx_ready,
    output logic              dev_tx_valid,
    output logic [DATA_W-1:0] dev_tx_data,
    output logic              dev_tx_par,
    input  logic              dev_tx_ready
);
    localparam int CMD_W = $bits(pio_cmd_e);

    typedef struct packed {
        logic              en;
        logic              ready;
        logic              busy;
        logic              perr;
        logic              rx_pend;
        logic              tx_pend;
        logic [DATA_W-1:0] rx_buf;
        logic [DATA_W-1:0] tx_buf;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    logic ctl_rd, ctl_wr, dat_rd, dat_wr;
    logic rx_par_calc, rx_bad, rx_fire, tx_fire;
    logic [DATA_W-1:0] status;
    pio_cmd_e cmd;

    pio_addr_decode #(.ADDR_W(ADDR_W), .DEV_BASE(DEV_BASE)) i_decode (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .ctl_rd  (ctl_rd),
        .ctl_wr  (ctl_wr),
        .dat_rd  (dat_rd),
        .dat_wr  (dat_wr)
    );

    pio_even_parity #(.W(DATA_W)) i_rx_par (
        .data(dev_rx_data),
        .par (rx_par_calc)
    );

    pio_even_parity #(.W(DATA_W)) i_tx_par (
        .data(state_q.tx_buf),
        .par (dev_tx_par)
    );

    always_comb begin
        status           = '0;
        status[ST_READY] = state_q.ready;
        status[ST_BUSY]  = state_q.busy;
        status[ST_PERR]  = state_q.perr;
        status[ST_EN]    = state_q.en;
        cmd              = pio_cmd_e'(bus_wdata[CMD_W-1:0]);
        rx_fire          = state_q.rx_pend && dev_rx_valid;
        tx_fire          = state_q.tx_pend && dev_tx_ready;
        rx_bad           = rx_par_calc != dev_rx_par;
    end

    always_comb begin
        state_d = state_q;

        // processor side
        if (ctl_rd) begin
            state_d.rdata = status;
            state_d.perr  = 1'b0;
        end
        if (dat_rd) begin
            state_d.rdata = state_q.rx_buf;
            state_d.ready = 1'b0;
        end
        if (dat_wr && !state_q.busy) begin
            state_d.tx_buf = bus_wdata;
        end
        if (ctl_wr) begin
            unique case (cmd)
                CMD_CTRL: state_d.en    = bus_wdata[CTRL_EN_BIT];
                CMD_TEST: state_d.rdata = status;
                CMD_READ: begin
                    if (state_q.en && !state_q.busy) begin
                        state_d.busy    = 1'b1;
                        state_d.rx_pend = 1'b1;
                        state_d.ready   = 1'b0;
                    end
                end
                CMD_WRITE: begin
                    if (state_q.en && !state_q.busy) begin
                        state_d.busy    = 1'b1;
                        state_d.tx_pend = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // device side
        if (rx_fire) begin
            state_d.rx_buf  = dev_rx_data;
            state_d.rx_pend = 1'b0;
            state_d.busy    = 1'b0;
            state_d.ready   = 1'b1;
            if (rx_bad) begin
                state_d.perr = 1'b1;
            end
        end
        if (tx_fire) begin
            state_d.tx_pend = 1'b0;
            state_d.busy    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata    = state_q.rdata;
    assign dev_enable   = state_q.en;
    assign dev_rx_ready = state_q.rx_pend;
    assign dev_tx_valid = state_q.tx_pend;
    assign dev_tx_data  = state_q.tx_buf;
endmodule

// File: rtl/pio_checker.sv
module pio_checker #(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 8,
    parameter logic [ADDR_W-2:0] DEV_BASE = 7'h2A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              dev_enable,
    input logic              dev_rx_valid,
    input logic              dev_rx_ready,
    input logic              dev_tx_valid,
    input logic [DATA_W-1:0] dev_tx_data,
    input logic              dev_tx_ready
);
    p_foreign_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && (bus_addr[ADDR_W-1:1] != DEV_BASE)
        |=> $stable(bus_rdata) && $stable(dev_enable));

    p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_rx_ready, dev_tx_valid}));

    p_rx_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rx_ready && !dev_rx_valid |=> dev_rx_ready);

    p_rx_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rx_ready && dev_rx_valid |=> !dev_rx_ready);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data));

    p_tx_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tx_valid && dev_tx_ready |=> !dev_tx_valid);
endmodule

bind polled_io_port pio_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DEV_BASE(DEV_BASE)
) i_pio_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .dev_enable  (dev_enable),
    .dev_rx_valid(dev_rx_valid),
    .dev_rx_ready(dev_rx_ready),
    .dev_tx_valid(dev_tx_valid),
    .dev_tx_data (dev_tx_data),
    .dev_tx_ready(dev_tx_ready)
);

// File: tb/test_polled_io_port.sv
`timescale 1ns/1ps
module test_polled_io_port;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam logic [6:0] BASE = 7'h2A;
    localparam logic [7:0] A_CTL = {BASE, 1'b0};
    localparam logic [7:0] A_DAT = {BASE, 1'b1};
    localparam logic [7:0] A_FOREIGN = 8'h56;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic dev_enable;
    logic dev_rx_valid = 1'b0;
    logic [7:0] dev_rx_data = '0;
    logic dev_rx_par = 1'b0;
    logic dev_rx_ready;
    logic dev_tx_valid;
    logic [7:0] dev_tx_data;
    logic dev_tx_par;
    logic dev_tx_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    polled_io_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_BASE(BASE)) i_polled_io_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_enable(dev_enable), .dev_rx_valid(dev_rx_valid),
        .dev_rx_data(dev_rx_data), .dev_rx_par(dev_rx_par),
        .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid),
        .dev_tx_data(dev_tx_data), .dev_tx_par(dev_tx_par),
        .dev_tx_ready(dev_tx_ready)
    );

    function automatic logic [7:0] st(bit rdy, bit busy, bit perr, bit en);
        return {4'b0000, en, perr, busy, rdy};
    endfunction

    function automatic logic epar(logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        return logic'(ones % 2);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_op(logic [7:0] d, bit bad, int lat);
        logic [7:0] r;
        bus_wr(A_CTL, 8'h02);
        check("R5 rx_ready after read cmd", dev_rx_ready, 1);
        bus_rd(A_CTL, r);
        check("R5 busy while pending", r, st(0, 1, 0, 1));
        repeat (lat) @(negedge clk);
        check("R5 still waiting", dev_rx_ready, 1);
        dev_rx_valid = 1'b1; dev_rx_data = d; dev_rx_par = epar(d) ^ bad;
        @(negedge clk);
        dev_rx_valid = 1'b0;
        check("R5 rx_ready drops", dev_rx_ready, 0);
        bus_rd(A_CTL, r);
        check("R8 status after rx", r, st(1, 0, bad, 1));
        if (bad) begin
            bus_rd(A_CTL, r);
            check("R8 perr cleared by status read", r, st(1, 0, 0, 1));
        end
        bus_rd(A_DAT, r);
        check("R7 data byte", r, d);
        bus_rd(A_CTL, r);
        check("R7 ready cleared", r, st(0, 0, 0, 1));
    endtask

    task automatic tx_op(logic [7:0] d, int lat);
        logic [7:0] r;
        bus_wr(A_DAT, d);
        bus_wr(A_CTL, 8'h03);
        check("R9 tx_valid", dev_tx_valid, 1);
        check("R9 tx_data", dev_tx_data, d);
        check("R9 tx_par even", dev_tx_par, epar(d));
        bus_rd(A_CTL, r);
        check("R9 busy during tx", r, st(0, 1, 0, 1));
        bus_wr(A_DAT, ~d);
        repeat (lat) @(negedge clk);
        check("R9 tx_data held", dev_tx_data, d);
        check("R9 tx_valid held", dev_tx_valid, 1);
        dev_tx_ready = 1'b1;
        @(negedge clk);
        dev_tx_ready = 1'b0;
        check("R9 tx_valid drops", dev_tx_valid, 0);
        bus_rd(A_CTL, r);
        check("R9 idle after tx", r, st(0, 0, 0, 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check("R2 rdata", bus_rdata, 0);
        check("R2 enable", dev_enable, 0);
        check("R2 rx_ready", dev_rx_ready, 0);
        check("R2 tx_valid", dev_tx_valid, 0);
        bus_rd(A_CTL, r);
        check("R2 status", r, st(0, 0, 0, 0));

        // R6 read and write while disabled
        bus_wr(A_CTL, 8'h02);
        check("R6 read ignored disabled", dev_rx_ready, 0);
        bus_wr(A_CTL, 8'h03);
        check("R6 write ignored disabled", dev_tx_valid, 0);
        bus_rd(A_CTL, r);
        check("R6 status disabled", r, st(0, 0, 0, 0));

        // R1 foreign address
        bus_wr(A_FOREIGN, 8'h04);
        check("R1 enable unchanged", dev_enable, 0);
        bus_rd(A_FOREIGN, r);
        check("R1 rdata unchanged", r, st(0, 0, 0, 0));
        bus_wr(8'h57, 8'h04);
        bus_rd(A_CTL, r);
        check("R1 status unchanged", r, st(0, 0, 0, 0));

        // R3 enable
        bus_wr(A_CTL, 8'h04);
        check("R3 dev_enable", dev_enable, 1);
        bus_rd(A_CTL, r);
        check("R3 status en", r, st(0, 0, 0, 1));

        // R10 device traffic with no read pending
        @(negedge clk);
        dev_rx_valid = 1'b1; dev_rx_data = 8'h5A; dev_rx_par = 1'b1;
        repeat (3) @(negedge clk);
        dev_rx_valid = 1'b0;
        bus_rd(A_DAT, r);
        check("R10 buffer untouched", r, 8'h00);
        bus_rd(A_CTL, r);
        check("R10 status untouched", r, st(0, 0, 0, 1));

        // R5/R6/R4/R8/R7 directed
        bus_wr(A_CTL, 8'h02);
        check("R5 rx_ready", dev_rx_ready, 1);
        bus_wr(A_CTL, 8'h02);
        bus_wr(A_CTL, 8'h03);
        check("R6 write ignored busy", dev_tx_valid, 0);
        check("R6 read pending kept", dev_rx_ready, 1);
        @(negedge clk);
        dev_rx_valid = 1'b1; dev_rx_data = 8'hA5; dev_rx_par = 1'b1;
        @(negedge clk);
        dev_rx_valid = 1'b0;
        bus_wr(A_CTL, 8'h01);
        check("R4 test returns status", bus_rdata, st(1, 0, 1, 1));
        bus_wr(A_CTL, 8'h01);
        check("R4 test keeps perr", bus_rdata, st(1, 0, 1, 1));
        bus_rd(A_CTL, r);
        check("R8 perr seen", r, st(1, 0, 1, 1));
        bus_rd(A_CTL, r);
        check("R8 perr cleared", r, st(1, 0, 0, 1));
        bus_rd(A_DAT, r);
        check("R7 byte", r, 8'hA5);
        bus_rd(A_CTL, r);
        check("R7 ready cleared", r, st(0, 0, 0, 1));
        bus_rd(A_DAT, r);
        check("R7 reread buffer", r, 8'hA5);
        bus_rd(A_CTL, r);
        check("R7 status unchanged", r, st(0, 0, 0, 1));

        // random mix
        for (int i = 0; i < 40; i++) begin
            rx_op(8'($urandom), ($urandom % 4) == 0, int'($urandom % 6));
            tx_op(8'($urandom), int'($urandom % 6));
        end
        rx_op(8'h00, 1'b1, 0);
        rx_op(8'hFF, 1'b0, 0);
        tx_op(8'h80, 0);

        // R3 disable
        bus_wr(A_CTL, 8'h00);
        check("R3 disabled", dev_enable, 0);
        bus_rd(A_CTL, r);
        check("R3 status disabled", r, st(0, 0, 0, 0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule